// File: doc/BRIEF.md
# DMA Channel Suspend and Event Control

This block holds the control state of a group of DMA channels. Each channel is idle, running or halted. The block takes software commands to start, suspend, resume and abort a channel, and it decodes the event-input action configured for that channel. It also receives block-end reports from the transfer engine and decides whether a suspend requested by the block action is honoured or cancelled by a pending skip. Toward the engine it drives a running and a halted indication, a gated trigger request and a block-start permission.

Each channel has three sticky interrupt flags, each with its own enable: bus error (bit 0), block complete (bit 1) and halted (bit 2). Software clears a flag by writing 1 to it. Only the low `EVT_CH` channels listen to their event input. The upper channels behave as if no event action were configured. Data movement and arbitration between channels are handled outside this block.

Top module: `dma_chsusp_ctl`

## Requirements
- R1: After reset every channel is idle, and all flags, trigger requests, block permissions and interrupt lines are 0.
- R2: A start command moves an idle channel to running and is ignored in the other states. A bus error on a running channel returns it to idle and sets flag bit 0.
- R3: A running channel halts on a software suspend, on an event strobe with action code 4, or on a block end whose 2-bit block action has bit 1 set. Flag bit 2 is set on the same clock edge that the channel enters the halted state, and never earlier.
- R4: A halted channel leaves that state only on a software resume, on an event strobe with action code 5, or on an abort. Block ends reported while halted are ignored.
- R5: An event strobe with action code 6 arms a skip. The skip cancels exactly one later block-end suspend and then disarms itself.
- R6: An abort returns a channel to idle from any state and clears its pending trigger. It takes priority over a start given in the same cycle and leaves the flags unchanged.
- R7: A trigger becomes pending on a software trigger or on an event strobe with action code 1. An acknowledge from the engine clears it. The trigger request is the pending trigger while the channel runs, further qualified by a high event level when the action code is 2.
- R8: Block-start permission equals "running". When the action code is 3, the event level must also be high.
- R9: A block end on a running channel whose block action has bit 0 set sets flag bit 1.
- R10: Writing 1 to a flag bit clears it, but a set in the same cycle wins. The channel's interrupt line is the OR of its flags masked by their enable bits.
- R11: A channel numbered `EVT_CH` or above ignores its event input under every action code.
- R12: When a halted channel receives suspend and resume in the same cycle, it resumes.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | NCH | Software start pulse per channel |
| cmd_suspend | input | NCH | Software suspend pulse per channel |
| cmd_resume | input | NCH | Software resume pulse per channel |
| cmd_abort | input | NCH | Software abort pulse per channel |
| cmd_trig | input | NCH | Software trigger pulse per channel |
| evt_in | input | NCH | Event input; a strobe or a level, depending on the action code |
| evt_act | input | 3*NCH | Event action code per channel, in 3-bit fields |
| blk_end | input | NCH | Block-complete pulse from the engine |
| blk_act | input | 2*NCH | Block action per channel: bit 0 sets complete, bit 1 requests suspend |
| bus_err | input | NCH | Transfer error pulse from the engine |
| trig_ack | input | NCH | Engine has taken the pending trigger |
| irq_mask | input | 3*NCH | Interrupt enables, 3 bits per channel |
| flag_clr | input | 3*NCH | Write-1-to-clear strobes for the flags |
| ch_active | output | NCH | Channel is running |
| ch_suspended | output | NCH | Channel is halted |
| trig_req | output | NCH | Qualified trigger request toward the engine |
| blk_allow | output | NCH | Engine may start a new block |
| irq_flags | output | 3*NCH | Flags: bit 0 error, bit 1 complete, bit 2 halted |
| irq | output | NCH | Per-channel interrupt line |

## Verification
The assertions assume single-cycle command and block-end pulses that are sampled on the rising clock edge. They assume that block ends and bus errors matter only for a running channel, and that an action code of 7 behaves as no action. The bench drives every input just after a falling edge, holds it for exactly one rising edge, and keeps the action code of a channel fixed while it pulses a strobe. This keeps the level-qualified codes 2 and 3 apart from the strobe-decoded ones. Same-cycle collisions are produced only on purpose: abort with start, set with clear, and suspend with resume.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RUN  = 2'd1,
    CH_HALT = 2'd2
  } ch_state_e;

  // Event action codes; the numeric value is decoded by software setup
  localparam logic [2:0] EA_NONE   = 3'd0;
  localparam logic [2:0] EA_TRIG   = 3'd1;
  localparam logic [2:0] EA_CTRIG  = 3'd2;
  localparam logic [2:0] EA_CBLK   = 3'd3;
  localparam logic [2:0] EA_SUSP   = 3'd4;
  localparam logic [2:0] EA_RESUME = 3'd5;
  localparam logic [2:0] EA_SKIP   = 3'd6;

  localparam int FLAGS_W   = 3;
  localparam int FLAG_ERR  = 0;
  localparam int FLAG_DONE = 1;
  localparam int FLAG_SUSP = 2;

  typedef struct packed {
    logic trig_ev;
    logic susp_ev;
    logic res_ev;
    logic skip_ev;
    logic trig_gate;
    logic blk_gate;
  } evt_cmd_t;

  localparam evt_cmd_t EVT_QUIET = '{trig_ev: 1'b0, susp_ev: 1'b0, res_ev: 1'b0,
                                     skip_ev: 1'b0, trig_gate: 1'b1, blk_gate: 1'b1};

  function automatic evt_cmd_t decode_evt(input logic [2:0] act, input logic lvl);
    evt_cmd_t r;
    r.trig_ev   = lvl && (act == EA_TRIG);
    r.susp_ev   = lvl && (act == EA_SUSP);
    r.res_ev    = lvl && (act == EA_RESUME);
    r.skip_ev   = lvl && (act == EA_SKIP);
    r.trig_gate = (act != EA_CTRIG) || lvl;
    r.blk_gate  = (act != EA_CBLK) || lvl;
    return r;
  endfunction

  function automatic logic irq_any(input logic [FLAGS_W-1:0] f, input logic [FLAGS_W-1:0] m);
    return |(f & m);
  endfunction

  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/dcc_evt_decode.sv
module dcc_evt_decode
  import dcc_pkg::*;
#(
  parameter bit HAS_EVT = 1'b1
) (
  input  logic [2:0] act,
  input  logic       evt,
  output evt_cmd_t   cmd
);
  assign cmd = HAS_EVT ? decode_evt(act, evt) : EVT_QUIET;
endmodule

// File: rtl/dcc_chan_fsm.sv
module dcc_chan_fsm
  import dcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_susp,
  input  logic       cmd_res,
  input  logic       cmd_abort,
  input  logic       cmd_trig,
  input  logic       ev_trig,
  input  logic       ev_susp,
  input  logic       ev_res,
  input  logic       ev_skip,
  input  logic       blk_end,
  input  logic [1:0] blk_act,
  input  logic       bus_err,
  input  logic       trig_ack,
  output ch_state_e  state,
  output logic       trig_pend,
  output logic       susp_enter,
  output logic       done_set,
  output logic       err_set
);
  ch_state_e nxt;
  logic      run, halt;
  logic      skip_pend;
  logic      blk_susp_req, skip_used, susp_req, res_req, err_hit;

  assign run          = (state == CH_RUN);
  assign halt         = (state == CH_HALT);
  assign blk_susp_req = run && blk_end && blk_act[1];
  assign skip_used    = blk_susp_req && skip_pend;
  assign susp_req     = run && (cmd_susp || ev_susp || (blk_susp_req && !skip_pend));
  assign res_req      = halt && (cmd_res || ev_res);
  assign err_hit      = run && bus_err && !cmd_abort;

  always_comb begin
    nxt = state;
    if (cmd_abort)    nxt = CH_IDLE;
    else if (err_hit) nxt = CH_IDLE;
    else begin
      case (state)
        CH_IDLE: if (cmd_start) nxt = CH_RUN;
        CH_RUN:  if (susp_req)  nxt = CH_HALT;
        CH_HALT: if (res_req)   nxt = CH_RUN;
        default: nxt = CH_IDLE;
      endcase
    end
  end

  assign susp_enter = susp_req && !cmd_abort && !err_hit;
  assign done_set   = run && blk_end && blk_act[0] && !cmd_abort;
  assign err_set    = err_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CH_IDLE;
      skip_pend <= 1'b0;
      trig_pend <= 1'b0;
    end else begin
      state <= nxt;
      if (cmd_abort)      skip_pend <= 1'b0;
      else if (ev_skip)   skip_pend <= 1'b1;
      else if (skip_used) skip_pend <= 1'b0;
      if (cmd_abort)                trig_pend <= 1'b0;
      else if (cmd_trig || ev_trig) trig_pend <= 1'b1;
      else if (trig_ack)            trig_pend <= 1'b0;
    end
  end

  p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> (state == CH_IDLE && !trig_pend));

  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_RUN && bus_err && !cmd_abort) |=> (state == CH_IDLE));

  p_skip_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_RUN && blk_end && blk_act[1] && skip_pend && !cmd_susp && !ev_susp
     && !cmd_abort && !bus_err && !ev_skip) |=> (state == CH_RUN && !skip_pend));

  p_halt_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CH_HALT && !cmd_res && !ev_res && !cmd_abort) |=> (state == CH_HALT));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ack && !cmd_trig && !ev_trig && !cmd_abort) |=> !trig_pend);
endmodule

// File: rtl/dcc_irq_flags.sv
module dcc_irq_flags
  import dcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLAGS_W-1:0] set,
  input  logic [FLAGS_W-1:0] clr,
  input  logic [FLAGS_W-1:0] mask,
  output logic [FLAGS_W-1:0] flags,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else
      for (int i = 0; i < FLAGS_W; i++)
        flags[i] <= next_flag(flags[i], set[i], clr[i]);
  end

  assign irq = irq_any(flags, mask);

  for (genvar i = 0; i < FLAGS_W; i++) begin : g_chk
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/dma_chsusp_ctl.sv
module dma_chsusp_ctl
  import dcc_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int EVT_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         cmd_start,
  input  logic [NCH-1:0]         cmd_suspend,
  input  logic [NCH-1:0]         cmd_resume,
  input  logic [NCH-1:0]         cmd_abort,
  input  logic [NCH-1:0]         cmd_trig,
  input  logic [NCH-1:0]         evt_in,
  input  logic [3*NCH-1:0]       evt_act,
  input  logic [NCH-1:0]         blk_end,
  input  logic [2*NCH-1:0]       blk_act,
  input  logic [NCH-1:0]         bus_err,
  input  logic [NCH-1:0]         trig_ack,
  input  logic [FLAGS_W*NCH-1:0] irq_mask,
  input  logic [FLAGS_W*NCH-1:0] flag_clr,
  output logic [NCH-1:0]         ch_active,
  output logic [NCH-1:0]         ch_suspended,
  output logic [NCH-1:0]         trig_req,
  output logic [NCH-1:0]         blk_allow,
  output logic [FLAGS_W*NCH-1:0] irq_flags,
  output logic [NCH-1:0]         irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    evt_cmd_t  ev;
    ch_state_e st;
    logic      pend, s_enter, d_set, e_set;
    logic [FLAGS_W-1:0] set_vec;

    dcc_evt_decode #(.HAS_EVT(c < EVT_CH)) u_dec (
      .act (evt_act[3*c +: 3]),
      .evt (evt_in[c]),
      .cmd (ev)
    );

    dcc_chan_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_start  (cmd_start[c]),
      .cmd_susp   (cmd_suspend[c]),
      .cmd_res    (cmd_resume[c]),
      .cmd_abort  (cmd_abort[c]),
      .cmd_trig   (cmd_trig[c]),
      .ev_trig    (ev.trig_ev),
      .ev_susp    (ev.susp_ev),
      .ev_res     (ev.res_ev),
      .ev_skip    (ev.skip_ev),
      .blk_end    (blk_end[c]),
      .blk_act    (blk_act[2*c +: 2]),
      .bus_err    (bus_err[c]),
      .trig_ack   (trig_ack[c]),
      .state      (st),
      .trig_pend  (pend),
      .susp_enter (s_enter),
      .done_set   (d_set),
      .err_set    (e_set)
    );

    always_comb begin
      set_vec            = '0;
      set_vec[FLAG_ERR]  = e_set;
      set_vec[FLAG_DONE] = d_set;
      set_vec[FLAG_SUSP] = s_enter;
    end

    dcc_irq_flags u_flg (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_vec),
      .clr   (flag_clr[FLAGS_W*c +: FLAGS_W]),
      .mask  (irq_mask[FLAGS_W*c +: FLAGS_W]),
      .flags (irq_flags[FLAGS_W*c +: FLAGS_W]),
      .irq   (irq[c])
    );

    assign ch_active[c]    = (st == CH_RUN);
    assign ch_suspended[c] = (st == CH_HALT);
    assign trig_req[c]     = pend && (st == CH_RUN) && ev.trig_gate;
    assign blk_allow[c]    = (st == CH_RUN) && ev.blk_gate;

    p_susp_flag_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[FLAGS_W*c + FLAG_SUSP]) |-> ch_suspended[c]);
  end
endmodule

// File: tb/dma_chsusp_ctl_bench.sv
module dma_chsusp_ctl_bench;
  localparam int NCH = 6;
  localparam int EVT_CH = 4;

  localparam int OP_EN = 0, OP_SUS = 1, OP_RES = 2, OP_ABT = 3, OP_TRG = 4, OP_ACK = 5,
                 OP_EVT = 6, OP_BLK = 7, OP_ERR = 8, OP_CLR = 9;

  function automatic logic [12:0] v(input int op, input int arg, input bit a, input bit s,
                                    input bit t, input logic [2:0] f);
    return {op[3:0], arg[2:0], a, s, t, f};
  endfunction

  localparam int NV = 28;
  localparam logic [12:0] VEC [NV] = '{
    v(OP_EN, 0,1,0,0,3'b000), v(OP_TRG,0,1,0,1,3'b000), v(OP_ACK,0,1,0,0,3'b000),
    v(OP_BLK,1,1,0,0,3'b010), v(OP_CLR,2,1,0,0,3'b000), v(OP_SUS,0,0,1,0,3'b100),
    v(OP_BLK,1,0,1,0,3'b100), v(OP_RES,0,1,0,0,3'b100), v(OP_CLR,4,1,0,0,3'b000),
    v(OP_EVT,6,1,0,0,3'b000), v(OP_BLK,2,1,0,0,3'b000), v(OP_BLK,2,0,1,0,3'b100),
    v(OP_EVT,5,1,0,0,3'b100), v(OP_EVT,4,0,1,0,3'b100), v(OP_CLR,4,0,1,0,3'b000),
    v(OP_EVT,1,0,1,0,3'b000), v(OP_RES,0,1,0,1,3'b000), v(OP_BLK,3,0,1,0,3'b110),
    v(OP_ABT,0,0,0,0,3'b110), v(OP_CLR,7,0,0,0,3'b000), v(OP_EN, 0,1,0,0,3'b000),
    v(OP_ERR,0,0,0,0,3'b001), v(OP_CLR,1,0,0,0,3'b000), v(OP_RES,0,0,0,0,3'b000),
    v(OP_EN, 0,1,0,0,3'b000), v(OP_EVT,0,1,0,0,3'b000), v(OP_EN, 0,1,0,0,3'b000),
    v(OP_ABT,0,0,0,0,3'b000)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] cmd_start, cmd_suspend, cmd_resume, cmd_abort, cmd_trig;
  logic [NCH-1:0] evt_in, blk_end, bus_err, trig_ack;
  logic [3*NCH-1:0] evt_act, irq_mask, flag_clr;
  logic [2*NCH-1:0] blk_act;
  logic [NCH-1:0] ch_active, ch_suspended, trig_req, blk_allow, irq;
  logic [3*NCH-1:0] irq_flags;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_chsusp_ctl #(.NCH(NCH), .EVT_CH(EVT_CH)) u_dma_chsusp_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_abort(cmd_abort), .cmd_trig(cmd_trig), .evt_in(evt_in),
    .evt_act(evt_act), .blk_end(blk_end), .blk_act(blk_act), .bus_err(bus_err),
    .trig_ack(trig_ack), .irq_mask(irq_mask), .flag_clr(flag_clr), .ch_active(ch_active),
    .ch_suspended(ch_suspended), .trig_req(trig_req), .blk_allow(blk_allow),
    .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic clear_pulses();
    cmd_start = '0; cmd_suspend = '0; cmd_resume = '0; cmd_abort = '0; cmd_trig = '0;
    blk_end = '0; bus_err = '0; trig_ack = '0; flag_clr = '0;
  endtask

  // Wait one rising edge, clear pulses after the falling edge, then settle
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clear_pulses();
    evt_in = '0;
    #1;
  endtask

  task automatic do_op(input int op, input int ch, input logic [2:0] arg);
    case (op)
      OP_EN:  cmd_start[ch] = 1'b1;
      OP_SUS: cmd_suspend[ch] = 1'b1;
      OP_RES: cmd_resume[ch] = 1'b1;
      OP_ABT: cmd_abort[ch] = 1'b1;
      OP_TRG: cmd_trig[ch] = 1'b1;
      OP_ACK: trig_ack[ch] = 1'b1;
      OP_EVT: begin evt_act[3*ch +: 3] = arg; evt_in[ch] = 1'b1; end
      OP_BLK: begin blk_end[ch] = 1'b1; blk_act[2*ch +: 2] = arg[1:0]; end
      OP_ERR: bus_err[ch] = 1'b1;
      OP_CLR: flag_clr[3*ch +: 3] = arg;
      default: ;
    endcase
    tick();
    evt_act[3*ch +: 3] = 3'd0;
  endtask

  function automatic string req_of(input int op, input int arg);
    case (op)
      OP_EN, OP_ERR: return "R2";
      OP_SUS:        return "R3";
      OP_RES:        return "R4";
      OP_ABT:        return "R6";
      OP_TRG, OP_ACK: return "R7";
      OP_CLR:        return "R10";
      OP_BLK:        return (arg[1] ? "R3" : "R9");
      default:       return (arg == 6) ? "R5" : (arg == 5) ? "R4" : (arg == 1) ? "R7" : "R3";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clear_pulses();
    evt_in = '0; evt_act = '0; blk_act = '0; irq_mask = '1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk({ch_active, ch_suspended, trig_req, blk_allow, irq} == '0 && irq_flags == '0,
        "R1", "reset outputs", {ch_active, ch_suspended, trig_req, blk_allow}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // Table walk on channel 0
    for (int i = 0; i < NV; i++) begin
      logic [12:0] e;
      logic [5:0] got, exp;
      e = VEC[i];
      do_op(int'(e[12:9]), 0, e[8:6]);
      got = {ch_active[0], ch_suspended[0], trig_req[0], irq_flags[2:0]};
      exp = e[5:0];
      chk(got == exp && irq[0] == (|e[2:0]), req_of(int'(e[12:9]), int'(e[8:6])),
          $sformatf("vector %0d", i), {26'd0, got}, {26'd0, exp});
    end

    // R11: upper channel ignores events
    do_op(OP_EN, 4, 0);
    do_op(OP_EVT, 4, 3'd4);
    chk(ch_active[4] && !ch_suspended[4], "R11", "ch4 event suspend ignored",
        {30'd0, ch_active[4], ch_suspended[4]}, 2);
    do_op(OP_EVT, 4, 3'd1);
    chk(!trig_req[4], "R11", "ch4 event trigger ignored", trig_req[4], 0);
    evt_act[14:12] = 3'd3; #1;
    chk(blk_allow[4], "R11", "ch4 conditional block ignored", blk_allow[4], 1);
    evt_act[14:12] = 3'd0;

    // R7: conditional trigger on channel 1
    do_op(OP_EN, 1, 0);
    evt_act[5:3] = 3'd2;
    cmd_trig[1] = 1'b1; tick();
    chk(!trig_req[1], "R7", "cond trigger held low level", trig_req[1], 0);
    evt_in[1] = 1'b1; #1;
    chk(trig_req[1], "R7", "cond trigger with level", trig_req[1], 1);
    evt_in[1] = 1'b0; evt_act[5:3] = 3'd0; #1;

    // R8: conditional block on channel 2
    do_op(OP_EN, 2, 0);
    evt_act[8:6] = 3'd3; #1;
    chk(!blk_allow[2], "R8", "block gate level low", blk_allow[2], 0);
    evt_in[2] = 1'b1; #1;
    chk(blk_allow[2], "R8", "block gate level high", blk_allow[2], 1);
    evt_in[2] = 1'b0; evt_act[8:6] = 3'd0; #1;
    chk(blk_allow[2] && !blk_allow[3], "R8", "plain run vs idle", {30'd0, blk_allow[3:2]}, 1);

    // R10: interrupt mask
    irq_mask[2:0] = 3'b000;
    do_op(OP_EN, 0, 0);
    do_op(OP_ERR, 0, 0);
    chk(irq_flags[2:0] == 3'b001 && !irq[0], "R10", "masked error flag",
        {28'd0, irq[0], irq_flags[2:0]}, 1);
    irq_mask[2:0] = 3'b001; #1;
    chk(irq[0], "R10", "unmasked irq", irq[0], 1);
    do_op(OP_CLR, 0, 3'b111);
    irq_mask[2:0] = 3'b111;

    // R10: set beats clear in the same cycle
    do_op(OP_EN, 0, 0);
    blk_end[0] = 1'b1; blk_act[1:0] = 2'b01; flag_clr[1] = 1'b1; tick();
    chk(irq_flags[1], "R10", "set wins over clear", irq_flags[1], 1);

    // R12: suspend and resume together while halted
    do_op(OP_SUS, 0, 0);
    cmd_suspend[0] = 1'b1; cmd_resume[0] = 1'b1; tick();
    chk(ch_active[0] && !ch_suspended[0], "R12", "resume wins when halted",
        {30'd0, ch_active[0], ch_suspended[0]}, 2);

    // R6: abort beats start
    do_op(OP_ABT, 0, 0);
    cmd_abort[0] = 1'b1; cmd_start[0] = 1'b1; tick();
    chk(!ch_active[0], "R6", "abort over start", ch_active[0], 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule